// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Tags

This block turns an asynchronous serial line into characters. It counts a 16x oversampling tick, finds a start bit, samples every later bit near the middle of its bit time, and then emits each character together with three tags: parity error, framing error and line break. The character format comes from the line-control byte that the matching transmitter also uses. That byte sets the length (5 to 8 bits), whether a parity bit is present, and the parity rule (even, odd or stick).

Each completed character ends in one of two ways, depending on the `fifo_full` input. Either the block raises a push strobe with an 11-bit word that a FIFO outside the block stores, or it drops the character and raises an overrun pulse. In both cases the block raises a character-seen pulse, which a receive-timeout counter elsewhere can use as its restart event. A loopback control switches the input from the external pin to the transmitter's internal serial output. When the divisor is zero, the tick never arrives and the block stays idle.

Top module: `async_rx_tagger`

## Requirements
- R1: After reset, `push_o`, `overrun_o`, `char_seen_o` and `push_word` are all 0.
- R2: A falling edge starts a character only if the line is still 0 when it is sampled about half a bit later. A shorter low pulse produces no character, and the receiver goes back to hunting.
- R3: Data bits arrive LSB first. The length is 5 + `line_cfg[1:0]` bits. The data lands in `push_word[7:0]`, right-justified, and the unused upper bits are 0.
- R4: When `line_cfg[3]` is set, a parity bit follows the data. With `line_cfg[5]`=0, `line_cfg[4]`=1 expects an even count of ones over data and parity, and 0 expects an odd count. With `line_cfg[5]`=1, the parity bit must be the inverse of `line_cfg[4]`. A mismatch sets `push_word[8]`.
- R5: Only the first stop bit is sampled. A 0 there sets `push_word[9]`. `line_cfg[2]` (the second stop bit) has no effect on reception, so a start bit right after one stop bit is accepted.
- R6: If start, data, parity and stop are all sampled 0, the block pushes one word of value 11'h400: only `push_word[10]` (the break tag) is set, and the data bits are zero.
- R7: After a stop bit sampled as 0 (a break or a framing error), no new start is accepted until the line has returned to 1.
- R8: If `fifo_full` is 1 in the cycle the stop bit is sampled, the character is dropped. `overrun_o` pulses, `push_o` stays 0, and `push_word` keeps its previous value.
- R9: `char_seen_o` pulses once for every completed character, whether it is pushed or dropped. It coincides with `push_o` or `overrun_o`.
- R10: With `lb_en`=1, the block receives from `lb_data` and ignores `rx_pin`.
- R11: While `tick16` stays 0, the block does not advance, whatever the line does.
- R12: `push_o` and `overrun_o` are single-cycle pulses and are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| rx_pin | input | 1 | External serial input (synchronised inside the block) |
| lb_en | input | 1 | Loopback select |
| lb_data | input | 1 | Transmitter serial output used in loopback |
| line_cfg | input | 8 | Line-control byte: [1:0] length, [2] stop count, [3] parity on, [4] even, [5] stick |
| fifo_full | input | 1 | The downstream FIFO cannot accept a word |
| push_o | output | 1 | Write strobe for `push_word` |
| push_word | output | 11 | {break, framing error, parity error, data[7:0]} |
| overrun_o | output | 1 | A completed character was dropped |
| char_seen_o | output | 1 | A character completed |

## Verification
The scoreboard sees several kinds of traffic, and each separates a different fault:
- Plain 8-bit and 5-bit frames show whether the bit order and the right-justification are correct.
- Even, odd and stick parity frames, each sent once with the correct parity bit and once with a flipped bit, test each parity rule on its own.
- A low stop bit, a line held low for a whole frame and beyond, and a frame sent with no idle gap after one stop bit tell a framing error from a break, and show that the receiver waits for the line to return high.
- A short low pulse, a frame sent with the tick held off, a frame sent while the pin is held low in loopback, and a frame sent with `fifo_full` set test start validation, the idle hold, the input select and the overrun path.

// File: rtl/async_rx_tagger.sv
module async_rx_tagger #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_pin,
  input  logic        lb_en,
  input  logic        lb_data,
  input  logic [7:0]  line_cfg,
  input  logic        fifo_full,
  output logic        push_o,
  output logic [10:0] push_word,
  output logic        overrun_o,
  output logic        char_seen_o
);
  localparam int DW        = 8;
  localparam int IW        = $clog2(DW);
  localparam int CW        = $clog2(OVS);
  localparam int START_CHK = OVS / 2 - 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t            state;
  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  bidx;
  logic [DW-1:0]  shreg;
  logic           all_zero;
  logic           par_bad;

  wire rx_line  = lb_en ? lb_data : sync_q[SYNC-1];
  wire bit_end  = (cnt == CW'(OVS - 1));
  wire [IW-1:0] last_idx = IW'(4 + {1'b0, line_cfg[1:0]});
  wire par_en   = line_cfg[3];
  wire par_even = line_cfg[4];
  wire par_stk  = line_cfg[5];
  wire par_exp  = par_stk ? ~par_even : (par_even ? ^shreg : ~^shreg);
  wire is_brk   = all_zero & ~rx_line;

  logic unused_cfg;
  assign unused_cfg = &{1'b0, line_cfg[7:6], line_cfg[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      bidx        <= '0;
      shreg       <= '0;
      all_zero    <= 1'b0;
      par_bad     <= 1'b0;
      push_o      <= 1'b0;
      overrun_o   <= 1'b0;
      char_seen_o <= 1'b0;
      push_word   <= '0;
    end else begin
      push_o      <= 1'b0;
      overrun_o   <= 1'b0;
      char_seen_o <= 1'b0;
      if (tick16) begin
        case (state)
          S_IDLE: if (!rx_line) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: begin
            if (cnt == CW'(START_CHK)) begin
              cnt <= '0;
              if (!rx_line) begin
                state    <= S_DATA;
                bidx     <= '0;
                shreg    <= '0;
                all_zero <= 1'b1;
                par_bad  <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              cnt         <= '0;
              shreg[bidx] <= rx_line;
              if (rx_line) all_zero <= 1'b0;
              if (bidx == last_idx) state <= par_en ? S_PAR : S_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (bit_end) begin
              cnt     <= '0;
              par_bad <= (rx_line != par_exp);
              if (rx_line) all_zero <= 1'b0;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              cnt         <= '0;
              char_seen_o <= 1'b1;
              push_o      <= ~fifo_full;
              overrun_o   <= fifo_full;
              if (!fifo_full)
                push_word <= is_brk ? 11'h400 : {1'b0, ~rx_line, par_bad, shreg};
              state <= rx_line ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: if (rx_line) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_tagger_chk.sv
module async_rx_tagger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick16,
  input logic        push_o,
  input logic        overrun_o,
  input logic        char_seen_o,
  input logic [10:0] push_word
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && overrun_o));

  p_push_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);

  p_seen_with_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    char_seen_o |-> (push_o || overrun_o));

  p_out_with_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o || overrun_o) |-> char_seen_o);

  p_brk_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && push_word[10]) |-> (push_word[9:0] == 10'h000));

  p_ovr_keeps_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $stable(push_word));

  p_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    char_seen_o |-> $past(tick16));
endmodule

bind async_rx_tagger async_rx_tagger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .push_o(push_o),
  .overrun_o(overrun_o), .char_seen_o(char_seen_o), .push_word(push_word)
);

// File: tb/sim_async_rx_tagger.sv
module sim_async_rx_tagger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic        rx_pin = 1'b1;
  logic        lb_en = 1'b0;
  logic        lb_data = 1'b1;
  logic [7:0]  line_cfg = 8'h03;
  logic        fifo_full = 1'b0;
  logic        push_o, overrun_o, char_seen_o;
  logic [10:0] push_word;

  int  n_chk = 0, n_fail = 0, n_seen = 0, n_exp = 0;
  bit  tick_en = 1'b1, use_lb = 1'b0, done = 1'b0;
  logic [11:0] sb[$];

  localparam int BITCLK = 64;

  async_rx_tagger u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin), .lb_en(lb_en),
    .lb_data(lb_data), .line_cfg(line_cfg), .fifo_full(fifo_full), .push_o(push_o),
    .push_word(push_word), .overrun_o(overrun_o), .char_seen_o(char_seen_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tick16 = tick_en && (tdiv == 0);
      tdiv = (tdiv + 1) % 4;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (char_seen_o) n_seen++;
      if (push_o && overrun_o) chk(0, "R12", "push and overrun together", 1, 0);
      if (push_o || overrun_o) begin
        if (sb.size() == 0) begin
          chk(0, "R9", "unexpected output word", int'(push_word), 0);
        end else begin
          logic [11:0] e;
          e = sb.pop_front();
          if (e[11]) chk(overrun_o && !push_o, "R8", "overrun expected", int'(push_o), 0);
          else chk(push_o && push_word == e[10:0], "R3-R6 word", "pushed word",
                   int'(push_word), int'(e[10:0]));
        end
      end
    end
  end

  task automatic drive_bit(input logic v);
    if (use_lb) lb_data = v; else rx_pin = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input logic par_flip, input logic stop_v,
                      input logic ovr, input bit idle);
    int nb;
    logic [7:0] dm;
    logic pcor;
    nb = 5 + int'(line_cfg[1:0]);
    dm = d & 8'(('1 << nb) ^ 9'h100) ;
    dm = d & ((8'hFF) >> (8 - nb));
    pcor = line_cfg[5] ? ~line_cfg[4] : (line_cfg[4] ? ^dm : ~^dm);
    sb.push_back({ovr, 1'b0, ~stop_v, par_flip & line_cfg[3], dm});
    n_exp++;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(dm[i]);
    if (line_cfg[3]) drive_bit(pcor ^ par_flip);
    drive_bit(stop_v);
    if (idle) drive_bit(1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(push_o == 0 && overrun_o == 0 && char_seen_o == 0 && push_word == 0,
        "R1", "outputs in reset", int'(push_word), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(push_o == 0 && overrun_o == 0 && char_seen_o == 0, "R1", "outputs after reset",
        int'({push_o, overrun_o, char_seen_o}), 0);
    drive_bit(1'b1);

    line_cfg = 8'h03;                      // R3 8-bit
    xfer(8'hA5, 0, 1, 0, 1);
    xfer(8'h3C, 0, 1, 0, 1);
    line_cfg = 8'h00;                      // R3 5-bit, upper bits zero
    xfer(8'hF5, 0, 1, 0, 1);

    line_cfg = 8'h1B;                      // R4 even
    xfer(8'h07, 0, 1, 0, 1);
    xfer(8'h07, 1, 1, 0, 1);
    line_cfg = 8'h0B;                      // R4 odd
    xfer(8'h81, 0, 1, 0, 1);
    xfer(8'h81, 1, 1, 0, 1);
    line_cfg = 8'h3B;                      // R4 stick even -> parity 0
    xfer(8'h11, 0, 1, 0, 1);
    xfer(8'h11, 1, 1, 0, 1);

    line_cfg = 8'h03;                      // R5 framing error, then R7 wait
    xfer(8'h81, 0, 0, 0, 1);
    line_cfg = 8'h07;                      // R5 second stop not required
    xfer(8'h96, 0, 1, 0, 0);
    xfer(8'h69, 0, 1, 0, 1);
    chk(n_seen == n_exp, "R9", "character count", n_seen, n_exp);

    line_cfg = 8'h03;                      // R6 break
    sb.push_back(12'h400);
    n_exp++;
    for (int i = 0; i < 12; i++) drive_bit(1'b0);
    chk(n_seen == n_exp, "R7", "no start while line stays low", n_seen, n_exp);
    drive_bit(1'b1);
    xfer(8'h5A, 0, 1, 0, 1);               // R7 normal reception resumes

    fifo_full = 1'b1;                      // R8 overrun
    xfer(8'h55, 0, 1, 1, 1);
    fifo_full = 1'b0;
    chk(push_word == 11'h05A, "R8", "word intact after overrun", int'(push_word), 11'h05A);
    chk(n_seen == n_exp, "R9", "overrun counted as character", n_seen, n_exp);

    rx_pin = 1'b0;                         // R2 short glitch
    repeat (16) @(negedge clk);
    rx_pin = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(n_seen == n_exp, "R2", "glitch produced no character", n_seen, n_exp);

    lb_en = 1'b1;                          // R10 loopback
    use_lb = 1'b1;
    repeat (4) @(negedge clk);
    rx_pin = 1'b0;
    xfer(8'hC3, 0, 1, 0, 1);
    xfer(8'h0F, 0, 1, 0, 1);
    rx_pin = 1'b1;
    repeat (8) @(negedge clk);
    lb_en = 1'b0;
    use_lb = 1'b0;
    chk(n_seen == n_exp, "R10", "loopback characters", n_seen, n_exp);

    tick_en = 1'b0;                        // R11 no tick
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(i[0]);
    drive_bit(1'b1);
    drive_bit(1'b1);
    tick_en = 1'b1;
    drive_bit(1'b1);
    chk(n_seen == n_exp && !push_o, "R11", "idle without tick", n_seen, n_exp);
    xfer(8'hE7, 0, 1, 0, 1);

    chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    chk(n_seen == n_exp, "R9", "final character count", n_seen, n_exp);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule